// File: doc/BRIEF.md
# Factory Bad-Block Scan Engine

This block runs once after power-up (or whenever software asks for it) and builds a table of the erase blocks that a small-page NAND device carries marked as defective from manufacture. It visits every block in ascending order. For each block it fetches one marker byte from the spare area of the block's first page and, when needed, of its second page. A block whose marker is anything other than FFh is recorded as bad. Block 0 is guaranteed good and is never recorded as bad.

The engine does not drive the device pins itself. It issues one operation at a time to a bus agent through a request/acknowledge port. The operations are: command byte, address byte, wait for ready, read one byte, and release chip enable. The agent owns all pin timing. Each marker fetch uses the spare-pointer read command at column offset 5, and chip enable is released after the single byte so that the device never runs on into a sequential row read. After the last block the engine writes the main-area pointer command, so the device is left in its normal read mode.

The result is a one-bit-per-block bitmap held in flops, read through a registered lookup port. Alongside it sit a saturating count of bad blocks and a flag that rises when the count passes a limit.

Top module: `nand_badblock_scan`

## Requirements
- R1: After reset, busy, done, limit_err and bus_req_valid are 0, bad_count is 0, and every bitmap bit reads 0.
- R2: A start pulse while idle or done sets busy in the next cycle. The first request is a command (op code 0) with byte 50h.
- R3: Each marker fetch issues, in order: command 50h (op 0); address 05h (op 1); address row[7:0], row[15:8] and row[23:16] (op 1 each); wait-ready (op 2); read (op 3); release (op 4). Here row = block×PAGES_PER_BLOCK + page. Each request is held unchanged until bus_ack.
- R4: Blocks are visited from 0 upward to NUM_BLOCKS−1. Within a block, page 0 is fetched before page 1.
- R5: A block is recorded bad (bitmap bit = 1) when either fetched marker differs from FFh.
- R6: When the page-0 marker already differs from FFh, no fetch of page 1 is issued for that block.
- R7: Block 0 is never recorded bad and never counted, whatever its markers hold.
- R8: After the last block the engine issues command 00h (op 0), then release (op 4). It then sets done and clears busy. done stays high until the next start.
- R9: Each accepted start clears the bitmap, bad_count and limit_err.
- R10: bad_count counts recorded bad blocks and holds at 2^COUNT_W−1 rather than wrapping.
- R11: limit_err rises when the number of recorded bad blocks exceeds BAD_LIMIT and stays high until the next start.
- R12: A start pulse while busy is ignored; the scan in progress continues unchanged.
- R13: rd_bad shows the bitmap bit of block rd_blk one cycle after rd_blk is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (pulse) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, held until next start |
| bus_req_valid | output | 1 | Operation request to the bus agent |
| bus_req_op | output | 3 | 0 command, 1 address, 2 wait-ready, 3 read, 4 release |
| bus_req_data | output | 8 | Command or address byte |
| bus_ack | input | 1 | Agent completed the current operation |
| bus_rsp_data | input | 8 | Byte returned by a read, valid with bus_ack |
| rd_blk | input | $clog2(NUM_BLOCKS) | Block number to look up |
| rd_bad | output | 1 | Bitmap bit of rd_blk, one cycle later |
| bad_count | output | COUNT_W | Saturating bad-block count |
| limit_err | output | 1 | Bad-block count exceeded BAD_LIMIT |

## Verification
A wrong step counter or row register shows up at once on the request port. The op code, or the address byte sent for a given block and page, departs from the sequence on the very next request, so a bus agent that predicts each request catches it within one operation. A wrong marker-decision flag shows in two places. The number of read operations changes during the scan, because a page-1 fetch is skipped or added. The block's bitmap bit and the count are then wrong as soon as the scan ends. A bitmap or counter that is not cleared only shows at the end of a second scan, as stale bits or an inflated count.

// File: rtl/nand_scan_pkg.sv
package nand_scan_pkg;

    typedef enum logic [2:0] {
        OP_CMD     = 3'd0,
        OP_ADDR    = 3'd1,
        OP_WAIT    = 3'd2,
        OP_READ    = 3'd3,
        OP_RELEASE = 3'd4
    } bus_op_e;

    typedef struct packed {
        bus_op_e    op;
        logic [7:0] data;
    } bus_req_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MARK,
        ST_PARK,
        ST_REL,
        ST_DONE
    } scan_state_e;

    typedef enum logic [2:0] {
        STP_CMD  = 3'd0,
        STP_COL  = 3'd1,
        STP_ROW0 = 3'd2,
        STP_ROW1 = 3'd3,
        STP_ROW2 = 3'd4,
        STP_WAIT = 3'd5,
        STP_READ = 3'd6,
        STP_REL  = 3'd7
    } fetch_step_e;

    localparam logic [7:0] CMD_SPARE_PTR = 8'h50;
    localparam logic [7:0] CMD_MAIN_PTR  = 8'h00;
    localparam logic [7:0] MARK_CLEAN    = 8'hFF;

    function automatic logic marker_is_bad(input logic [7:0] b);
        return b != MARK_CLEAN;
    endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import nand_scan_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4096,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int MARKER_COL      = 5,
    parameter int BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             clear,
    output logic             req_valid,
    output bus_req_t         req,
    input  logic             ack,
    input  logic [7:0]       rsp_data,
    output logic             res_valid,
    output logic [BLK_W-1:0] res_blk,
    output logic             res_bad
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_e      state_q;
    fetch_step_e      step_q;
    logic [BLK_W-1:0] blk_q;
    logic             page_q;
    logic             flag_q;
    logic [23:0]      row;
    logic             start_ok;

    assign row      = 24'(blk_q) * 24'(PAGES_PER_BLOCK) + 24'(page_q);
    assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign clear    = start_ok;
    assign busy     = (state_q == ST_MARK) || (state_q == ST_PARK) || (state_q == ST_REL);
    assign done     = (state_q == ST_DONE);

    always_comb begin
        req_valid = 1'b0;
        req.op    = OP_CMD;
        req.data  = 8'h00;
        case (state_q)
            ST_MARK: begin
                req_valid = 1'b1;
                case (step_q)
                    STP_CMD:  begin req.op = OP_CMD;     req.data = CMD_SPARE_PTR; end
                    STP_COL:  begin req.op = OP_ADDR;    req.data = 8'(MARKER_COL); end
                    STP_ROW0: begin req.op = OP_ADDR;    req.data = row[7:0]; end
                    STP_ROW1: begin req.op = OP_ADDR;    req.data = row[15:8]; end
                    STP_ROW2: begin req.op = OP_ADDR;    req.data = row[23:16]; end
                    STP_WAIT: begin req.op = OP_WAIT;    req.data = 8'h00; end
                    STP_READ: begin req.op = OP_READ;    req.data = 8'h00; end
                    default:  begin req.op = OP_RELEASE; req.data = 8'h00; end
                endcase
            end
            ST_PARK: begin
                req_valid = 1'b1;
                req.op    = OP_CMD;
                req.data  = CMD_MAIN_PTR;
            end
            ST_REL: begin
                req_valid = 1'b1;
                req.op    = OP_RELEASE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            step_q    <= STP_CMD;
            blk_q     <= '0;
            page_q    <= 1'b0;
            flag_q    <= 1'b0;
            res_valid <= 1'b0;
            res_blk   <= '0;
            res_bad   <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start_ok) begin
                        state_q <= ST_MARK;
                        step_q  <= STP_CMD;
                        blk_q   <= '0;
                        page_q  <= 1'b0;
                        flag_q  <= 1'b0;
                    end
                end
                ST_MARK: begin
                    if (ack) begin
                        if (step_q == STP_READ) begin
                            flag_q <= flag_q | marker_is_bad(rsp_data);
                        end
                        if (step_q == STP_REL) begin
                            step_q <= STP_CMD;
                            if (!page_q && !flag_q) begin
                                page_q <= 1'b1;
                            end else begin
                                res_valid <= 1'b1;
                                res_blk   <= blk_q;
                                res_bad   <= flag_q && (blk_q != '0);
                                page_q    <= 1'b0;
                                flag_q    <= 1'b0;
                                if (blk_q == LAST_BLK) state_q <= ST_PARK;
                                else                   blk_q   <= blk_q + 1'b1;
                            end
                        end else begin
                            step_q <= fetch_step_e'(step_q + 3'd1);
                        end
                    end
                end
                ST_PARK: if (ack) state_q <= ST_REL;
                ST_REL:  if (ack) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R3: a request stays put until the agent acknowledges it
    a_r3_req_held: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ack) |=> (req_valid && $stable(req)));

    // R8: the engine is never busy and done together
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R2: the first request of a scan is the spare-pointer command
    a_r2_first_op: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (req_valid && req.op == OP_CMD && req.data == CMD_SPARE_PTR));

    // R6: a second-page fetch starts only when the first marker was clean
    a_r6_skip_second: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MARK && page_q) |-> !flag_q || step_q > STP_READ);

    // R12: start while busy leaves the block number unchanged
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !ack) |=> $stable(blk_q));

endmodule

// File: rtl/bad_map.sv
module bad_map #(
    parameter int NUM_BLOCKS = 4096,
    parameter int BLK_W      = $clog2(NUM_BLOCKS),
    parameter int WORD_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_blk,
    input  logic             set_bad,
    input  logic [BLK_W-1:0] rd_blk,
    output logic             rd_bad
);

    localparam int WORDS  = (NUM_BLOCKS + WORD_W - 1) / WORD_W;
    localparam int IDX_W  = $clog2(WORD_W);
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [WORD_W-1:0] mem_q [WORDS];
    logic [WSEL_W-1:0] set_w, rd_w;
    logic [IDX_W-1:0]  set_b, rd_b;

    assign set_w = WSEL_W'(set_blk >> IDX_W);
    assign set_b = IDX_W'(set_blk);
    assign rd_w  = WSEL_W'(rd_blk >> IDX_W);
    assign rd_b  = IDX_W'(rd_blk);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
        end else if (set_en && set_bad) begin
            mem_q[set_w][set_b] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_bad <= 1'b0;
        else     rd_bad <= mem_q[rd_w][rd_b];
    end

    // R7: the sequencer never hands over block 0 as bad
    a_r7_blk0_clean: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !(set_blk == '0 && set_bad));

    // R9: the lookup right after a clear reads zero
    a_r9_map_cleared: assert property (@(posedge clk) disable iff (rst)
        (clear && !set_en) |=> ##1 (!rd_bad || $past(set_en)));

endmodule

// File: rtl/bad_counter.sv
module bad_counter #(
    parameter int COUNT_W   = 8,
    parameter int BAD_LIMIT = 70
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               inc,
    output logic [COUNT_W-1:0] count,
    output logic               err
);

    localparam logic [COUNT_W-1:0] MAXV = {COUNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            err   <= 1'b0;
        end else if (inc) begin
            if (count != MAXV) count <= count + 1'b1;
            if (int'(count) >= BAD_LIMIT) err <= 1'b1;
        end
    end

    // R10: a full counter holds its value
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (rst)
        (!clear && inc && count == MAXV) |=> (count == MAXV));

    // R11: the flag only stands when the count is above the limit
    a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
        err |-> (int'(count) > BAD_LIMIT));

    // R11: the flag is sticky within a scan
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !clear) |=> err);

    // R9: a clear zeroes count and flag
    a_r9_count_cleared: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0 && !err));

endmodule

// File: rtl/nand_badblock_scan.sv
module nand_badblock_scan
    import nand_scan_pkg::*;
#(
    parameter int NUM_BLOCKS      = 4096,
    parameter int PAGES_PER_BLOCK = 32,
    parameter int MARKER_COL      = 5,
    parameter int BAD_LIMIT       = 70,
    parameter int COUNT_W         = 8,
    parameter int BLK_W           = $clog2(NUM_BLOCKS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               bus_req_valid,
    output logic [2:0]         bus_req_op,
    output logic [7:0]         bus_req_data,
    input  logic               bus_ack,
    input  logic [7:0]         bus_rsp_data,
    input  logic [BLK_W-1:0]   rd_blk,
    output logic               rd_bad,
    output logic [COUNT_W-1:0] bad_count,
    output logic               limit_err
);

    bus_req_t         req;
    logic             clear;
    logic             res_valid;
    logic [BLK_W-1:0] res_blk;
    logic             res_bad;

    scan_sequencer #(
        .NUM_BLOCKS      (NUM_BLOCKS),
        .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
        .MARKER_COL      (MARKER_COL),
        .BLK_W           (BLK_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .busy      (busy),
        .done      (done),
        .clear     (clear),
        .req_valid (bus_req_valid),
        .req       (req),
        .ack       (bus_ack),
        .rsp_data  (bus_rsp_data),
        .res_valid (res_valid),
        .res_blk   (res_blk),
        .res_bad   (res_bad)
    );

    assign bus_req_op   = req.op;
    assign bus_req_data = req.data;

    bad_map #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_W      (BLK_W)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .set_en  (res_valid),
        .set_blk (res_blk),
        .set_bad (res_bad),
        .rd_blk  (rd_blk),
        .rd_bad  (rd_bad)
    );

    bad_counter #(
        .COUNT_W   (COUNT_W),
        .BAD_LIMIT (BAD_LIMIT)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .inc   (res_valid && res_bad),
        .count (bad_count),
        .err   (limit_err)
    );

endmodule

// File: tb/tb_nand_badblock_scan.sv
module tb_nand_badblock_scan;

    localparam int NB    = 64;
    localparam int PPB   = 32;
    localparam int LIMIT = 6;
    localparam int CW    = 4;
    localparam int BW    = $clog2(NB);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          busy, done, bus_req_valid, rd_bad, limit_err;
    logic [2:0]    bus_req_op;
    logic [7:0]    bus_req_data;
    logic          bus_ack = 1'b0;
    logic [7:0]    bus_rsp_data = 8'h00;
    logic [BW-1:0] rd_blk = '0;
    logic [CW-1:0] bad_count;

    always #5 clk = ~clk;

    nand_badblock_scan #(
        .NUM_BLOCKS      (NB),
        .PAGES_PER_BLOCK (PPB),
        .MARKER_COL      (5),
        .BAD_LIMIT       (LIMIT),
        .COUNT_W         (CW)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .busy          (busy),
        .done          (done),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (bus_req_op),
        .bus_req_data  (bus_req_data),
        .bus_ack       (bus_ack),
        .bus_rsp_data  (bus_rsp_data),
        .rd_blk        (rd_blk),
        .rd_bad        (rd_bad),
        .bad_count     (bad_count),
        .limit_err     (limit_err)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] mark0 [NB];
    logic [7:0] mark1 [NB];
    int e_blk, e_page, e_step, e_fin, seq_err, reads;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic gen_reset();
        e_blk = 0; e_page = 0; e_step = 0; e_fin = 0; seq_err = 0; reads = 0;
    endtask

    // bus agent model: predicts every request and answers reads from the marker tables
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req_valid) begin
                logic [2:0]  xo;
                logic [7:0]  xd;
                logic [23:0] row;
                bit          cmp_d;
                row   = 24'(e_blk * PPB + e_page);
                cmp_d = 1'b0;
                xo    = 3'd7;
                xd    = 8'h00;
                if (e_fin == 0) begin
                    case (e_step)
                        0: begin xo = 3'd0; xd = 8'h50; cmp_d = 1'b1; end
                        1: begin xo = 3'd1; xd = 8'h05; cmp_d = 1'b1; end
                        2: begin xo = 3'd1; xd = row[7:0]; cmp_d = 1'b1; end
                        3: begin xo = 3'd1; xd = row[15:8]; cmp_d = 1'b1; end
                        4: begin xo = 3'd1; xd = row[23:16]; cmp_d = 1'b1; end
                        5: xo = 3'd2;
                        6: xo = 3'd3;
                        default: xo = 3'd4;
                    endcase
                end else if (e_fin == 1) begin
                    xo = 3'd0; xd = 8'h00; cmp_d = 1'b1;
                end else if (e_fin == 2) begin
                    xo = 3'd4;
                end
                if (bus_req_op !== xo || (cmp_d && bus_req_data !== xd)) seq_err++;
                if (e_fin == 0 && e_step == 6) begin
                    bus_rsp_data = (e_page == 1) ? mark1[e_blk] : mark0[e_blk];
                    reads++;
                end
                if (e_fin == 0) begin
                    if (e_step == 7) begin
                        e_step = 0;
                        if (e_page == 0 && mark0[e_blk] == 8'hFF) begin
                            e_page = 1;
                        end else begin
                            e_page = 0;
                            if (e_blk == NB - 1) e_fin = 1;
                            else                 e_blk++;
                        end
                    end else begin
                        e_step++;
                    end
                end else begin
                    e_fin++;
                end
                bus_ack = 1'b1;
            end
        end
    end

    task automatic fill_clean();
        for (int b = 0; b < NB; b++) begin
            mark0[b] = 8'hFF;
            mark1[b] = 8'hFF;
        end
    endtask

    task automatic check_map(input string tag);
        for (int b = 0; b < NB; b++) begin
            logic exp;
            exp = (b != 0) && (mark0[b] != 8'hFF || mark1[b] != 8'hFF);
            rd_blk = BW'(b);
            @(negedge clk);
            checks++;
            if (rd_bad !== exp) begin
                errors++;
                $display("FAIL %s R5/R7/R13 map block %0d actual %0b expected %0b",
                         tag, b, rd_bad, exp);
            end
        end
    endtask

    task automatic run_scan(input string tag, input bit poke);
        int exp_bad, exp_reads, cyc;
        exp_bad = 0;
        exp_reads = 0;
        for (int b = 0; b < NB; b++) begin
            if (b != 0 && (mark0[b] != 8'hFF || mark1[b] != 8'hFF)) exp_bad++;
            exp_reads += (mark0[b] != 8'hFF) ? 1 : 2;
        end
        gen_reset();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2", {tag, " busy after start"}, 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 301) start = 1'b1;
            if (poke && cyc == 302) start = 1'b0;
        end
        check("R8", {tag, " done reached"}, 32'(done), 32'd1);
        check("R8", {tag, " busy low at end"}, 32'(busy), 32'd0);
        check(poke ? "R12" : "R3", {tag, " request sequence mismatches"}, 32'(seq_err), 32'd0);
        check("R4", {tag, " last block visited"}, 32'(e_blk), 32'(NB - 1));
        check("R8", {tag, " pointer restore and release seen"}, 32'(e_fin), 32'd3);
        check("R6", {tag, " marker reads"}, 32'(reads), 32'(exp_reads));
        check("R10", {tag, " bad count"}, 32'(bad_count),
              32'((exp_bad > (1 << CW) - 1) ? (1 << CW) - 1 : exp_bad));
        check("R11", {tag, " limit flag"}, 32'(limit_err), 32'(exp_bad > LIMIT));
        repeat (5) @(negedge clk);
        check("R8", {tag, " done held"}, 32'(done), 32'd1);
        check("R8", {tag, " bus idle after done"}, 32'(bus_req_valid), 32'd0);
        check_map(tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "busy", 32'(busy), 32'd0);
        check("R1", "done", 32'(done), 32'd0);
        check("R1", "bus_req_valid", 32'(bus_req_valid), 32'd0);
        check("R1", "bad_count", 32'(bad_count), 32'd0);
        check("R1", "limit_err", 32'(limit_err), 32'd0);
        fill_clean();
        check_map("reset R1");
    endtask

    task automatic t_all_clean();
        fill_clean();
        run_scan("clean", 1'b0);
    endtask

    task automatic t_few_bad();
        fill_clean();
        mark0[0]  = 8'h00;   // R7: block 0 marked but must stay clean
        mark1[0]  = 8'h12;
        mark0[3]  = 8'hFE;   // page-0 marker, R6 skip
        mark1[7]  = 8'h00;   // page-1 marker
        mark0[31] = 8'h7F;
        mark1[32] = 8'hEF;
        mark0[40] = 8'h00;
        mark1[40] = 8'h00;
        mark1[NB-1] = 8'hBF; // last block
        run_scan("six bad at limit", 1'b0);
    endtask

    task automatic t_many_bad();
        fill_clean();
        for (int b = 1; b <= 20; b++) begin
            if (b % 2 == 0) mark0[b] = 8'(b);
            else            mark1[b] = 8'(b);
        end
        run_scan("twenty bad", 1'b0);
    endtask

    task automatic t_rescan_clears();
        fill_clean();
        run_scan("R9 rescan clean", 1'b0);
    endtask

    task automatic t_start_while_busy();
        fill_clean();
        mark1[10] = 8'h01;
        mark0[50] = 8'h55;
        run_scan("R12 start during scan", 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_all_clean();
        t_few_bad();
        t_many_bad();
        t_rescan_clears();
        t_start_while_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule